// File: doc/BRIEF.md
# Clock Failure Detection Monitor

This block checks that a chosen clock source is still toggling. A free-running reference clock times the check. Every source feeds its own toggle flop, which runs in that source's domain. A synchronizer carries each toggle into the reference domain, and the source-select input then picks one of these synchronized toggles. The reference domain runs a repeating window of ten cycles. In the first eight cycles, any change of the selected toggle counts as proof of life. The ninth cycle judges the window. The tenth cycle clears the record before the next window starts.

When a window ends with no recorded activity, the block declares a failure. It sets a sticky interrupt flag and raises an interrupt if that is enabled. It also pulses a notification to the error controller. If the failed source is the main clock (select value 0), the response also depends on what drives the main clock. When the main clock comes from an external crystal or external clock input, the block commands a switch to the internal oscillator and a return of the clock configuration to its defaults. Otherwise it requests a machine-check reset. Clock muxing, error handling and reset generation are done by neighbouring blocks.

Top module: `clk_fail_mon`

## Requirements
- R1: With a stopped selected clock, the first failure becomes visible after the 9th rising reference edge that sees `enable` high. Later judgments fall every 10 edges after that.
- R2: A selected clock that keeps toggling never produces a failure.
- R3: Only the source picked by `src_sel` (binary index, 0 to 3) is judged. A stopped source that is not selected has no effect, and a stopped selected source fails even when all the others run.
- R4: `irq_flag` is 0 after reset. It is set by a failure and holds until `flag_clr` is high at a rising edge.
- R5: `irq` equals `irq_flag` AND `irq_en`.
- R6: `err_pulse` is high for exactly one reference cycle per declared failure, for every source.
- R7: A failure with `src_sel`=0 and `main_ext`=0 pulses `mc_reset_req` for one cycle. No other case pulses it.
- R8: A failure with `src_sel`=0 and `main_ext`=1 pulses `switch_int_osc` and `cfg_to_default` together for one cycle. No other case pulses them.
- R9: While `enable` is low, the window counter and the activity record are held at zero and no failure is declared. Re-enabling starts a fresh 10-cycle window.
- R10: After a failure, later empty windows declare nothing until `flag_clr` is applied or the monitor is re-enabled. After a clear, the next empty window fires again.
- R11: If `flag_clr` coincides with a judgment that finds an empty window, the failure wins. The flag stays set and all pulses are emitted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk | input | 1 | Reference clock that times the windows |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_clk | input | NUM_SRC | Candidate clocks to be watched |
| enable | input | 1 | Monitor enable |
| src_sel | input | SEL_W | Index of the watched clock; MAIN_SEL (0) is the main clock |
| main_ext | input | 1 | Main clock is driven by external crystal or clock input |
| irq_en | input | 1 | Interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for the flag |
| irq_flag | output | 1 | Sticky failure flag |
| irq | output | 1 | Interrupt request |
| err_pulse | output | 1 | One-cycle notification to error controller |
| mc_reset_req | output | 1 | One-cycle machine-check reset request |
| switch_int_osc | output | 1 | One-cycle command to move main clock to internal oscillator |
| cfg_to_default | output | 1 | One-cycle command to restore prescaler and clear clock-output bits |

## Verification
A software clear of the flag and a new failure judgment can fall in the same reference cycle. The bench provokes this by holding the selected clock stopped after an earlier failure, so the suppression latch is set. It then raises `flag_clr` exactly at the edge of a later judgment slot. That edge must still show a notification pulse and leave the flag set. A clear applied outside a judgment slot must drop the flag and re-arm the monitor, so the next empty window fires again.

// File: rtl/cfm_pkg.sv
package cfm_pkg;
   typedef enum logic [1:0] {
      PH_SAMPLE = 2'd0,
      PH_JUDGE  = 2'd1,
      PH_CLEAR  = 2'd2
   } cfm_phase_e;
endpackage

// File: rtl/cfm_edge_capture.sv
module cfm_edge_capture #(
   parameter int NUM_SRC     = 4,
   parameter int SYNC_STAGES = 2
) (
   input  logic               ref_clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] mon_clk,
   output logic [NUM_SRC-1:0] tog_sync
);
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("cfm_edge_capture: SYNC_STAGES must be at least 2");
   end

   for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
      logic                   tog;
      logic [SYNC_STAGES-1:0] chain;

      // toggle flop in the watched clock's own domain
      always_ff @(posedge mon_clk[g] or negedge rst_n) begin
         if (!rst_n) tog <= 1'b0;
         else        tog <= ~tog;
      end

      // resynchronize into the reference domain
      always_ff @(posedge ref_clk or negedge rst_n) begin
         if (!rst_n) chain <= '0;
         else        chain <= {chain[SYNC_STAGES-2:0], tog};
      end

      assign tog_sync[g] = chain[SYNC_STAGES-1];
   end
endmodule

// File: rtl/cfm_window_timer.sv
module cfm_window_timer
   import cfm_pkg::*;
#(
   parameter int WIN_LEN    = 10,
   parameter int SAMPLE_LEN = 8
) (
   input  logic                       ref_clk,
   input  logic                       rst_n,
   input  logic                       enable,
   output logic [$clog2(WIN_LEN)-1:0] cnt,
   output cfm_phase_e                 phase
);
   localparam int CNT_W = $clog2(WIN_LEN);
   localparam logic [CNT_W-1:0] LAST  = CNT_W'(WIN_LEN - 1);
   localparam logic [CNT_W-1:0] JUDGE = CNT_W'(SAMPLE_LEN);

   if (WIN_LEN < SAMPLE_LEN + 2) begin : g_bad_win
      $error("cfm_window_timer: window needs a judge and a clear slot");
   end
   if (SAMPLE_LEN < 1) begin : g_bad_sample
      $error("cfm_window_timer: SAMPLE_LEN must be positive");
   end

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n)           cnt <= '0;
      else if (!enable)     cnt <= '0;
      else if (cnt == LAST) cnt <= '0;
      else                  cnt <= cnt + 1'b1;
   end

   always_comb begin
      if (cnt < JUDGE)       phase = PH_SAMPLE;
      else if (cnt == JUDGE) phase = PH_JUDGE;
      else                   phase = PH_CLEAR;
   end

   a_r1_cnt_bound: assert property (@(posedge ref_clk) disable iff (!rst_n)
      cnt <= LAST);
   a_r9_hold_zero: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !enable |=> cnt == '0);
endmodule

// File: rtl/cfm_activity_judge.sv
module cfm_activity_judge
   import cfm_pkg::*;
(
   input  logic       ref_clk,
   input  logic       rst_n,
   input  logic       enable,
   input  logic       sel_tog,
   input  cfm_phase_e phase,
   input  logic       flag_clr,
   output logic       fail_det
);
   logic prev_tog;
   logic seen;
   logic latched;

   assign fail_det = enable && (phase == PH_JUDGE) && !seen && (!latched || flag_clr);

   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_tog <= 1'b0;
         seen     <= 1'b0;
         latched  <= 1'b0;
      end else begin
         prev_tog <= sel_tog;
         if (!enable) begin
            seen    <= 1'b0;
            latched <= 1'b0;
         end else begin
            case (phase)
               PH_SAMPLE: if (sel_tog != prev_tog) seen <= 1'b1;
               PH_CLEAR:  seen <= 1'b0;
               default:   ;
            endcase
            if (fail_det)      latched <= 1'b1;
            else if (flag_clr) latched <= 1'b0;
         end
      end
   end

   a_r2_clear_slot: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (enable && phase == PH_CLEAR) |=> !seen);
   a_r10_latch_holds: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (latched && enable && !flag_clr) |=> latched);
endmodule

// File: rtl/cfm_fail_response.sv
module cfm_fail_response (
   input  logic ref_clk,
   input  logic rst_n,
   input  logic fail_det,
   input  logic is_main,
   input  logic main_ext,
   input  logic irq_en,
   input  logic flag_clr,
   output logic irq_flag,
   output logic irq,
   output logic err_pulse,
   output logic mc_reset_req,
   output logic switch_int_osc,
   output logic cfg_to_default
);
   always_ff @(posedge ref_clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_flag       <= 1'b0;
         err_pulse      <= 1'b0;
         mc_reset_req   <= 1'b0;
         switch_int_osc <= 1'b0;
         cfg_to_default <= 1'b0;
      end else begin
         if (fail_det)      irq_flag <= 1'b1;
         else if (flag_clr) irq_flag <= 1'b0;
         err_pulse      <= fail_det;
         mc_reset_req   <= fail_det && is_main && !main_ext;
         switch_int_osc <= fail_det && is_main && main_ext;
         cfg_to_default <= fail_det && is_main && main_ext;
      end
   end

   assign irq = irq_flag && irq_en;

   a_r6_single_pulse: assert property (@(posedge ref_clk) disable iff (!rst_n)
      err_pulse |=> !err_pulse);
   a_r7_r8_exclusive: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !(mc_reset_req && switch_int_osc));
   a_r7_reset_has_err: assert property (@(posedge ref_clk) disable iff (!rst_n)
      mc_reset_req |-> err_pulse && irq_flag);
   a_r4_sticky: assert property (@(posedge ref_clk) disable iff (!rst_n)
      (irq_flag && !flag_clr) |=> irq_flag);
endmodule

// File: rtl/clk_fail_mon.sv
module clk_fail_mon
   import cfm_pkg::*;
#(
   parameter int NUM_SRC     = 4,
   parameter int MAIN_SEL    = 0,
   parameter int WIN_LEN     = 10,
   parameter int SAMPLE_LEN  = 8,
   parameter int SYNC_STAGES = 2,
   parameter int SEL_W       = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
   input  logic               ref_clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] mon_clk,
   input  logic               enable,
   input  logic [SEL_W-1:0]   src_sel,
   input  logic               main_ext,
   input  logic               irq_en,
   input  logic               flag_clr,
   output logic               irq_flag,
   output logic               irq,
   output logic               err_pulse,
   output logic               mc_reset_req,
   output logic               switch_int_osc,
   output logic               cfg_to_default
);
   localparam int CNT_W = $clog2(WIN_LEN);

   if (NUM_SRC < 1) begin : g_bad_src
      $error("clk_fail_mon: NUM_SRC must be positive");
   end
   if (MAIN_SEL >= NUM_SRC) begin : g_bad_main
      $error("clk_fail_mon: MAIN_SEL out of range");
   end

   logic [NUM_SRC-1:0] tog_sync;
   logic [CNT_W-1:0]   cnt;
   cfm_phase_e         phase;
   logic               sel_tog;
   logic               is_main;
   logic               fail_det;

   cfm_edge_capture #(
      .NUM_SRC    (NUM_SRC),
      .SYNC_STAGES(SYNC_STAGES)
   ) u_capture (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .mon_clk (mon_clk),
      .tog_sync(tog_sync)
   );

   cfm_window_timer #(
      .WIN_LEN   (WIN_LEN),
      .SAMPLE_LEN(SAMPLE_LEN)
   ) u_timer (
      .ref_clk(ref_clk),
      .rst_n  (rst_n),
      .enable (enable),
      .cnt    (cnt),
      .phase  (phase)
   );

   // an out-of-range index watches nothing and therefore reports a failure
   assign sel_tog = (int'(src_sel) < NUM_SRC) ? tog_sync[src_sel] : 1'b0;
   assign is_main = (src_sel == SEL_W'(MAIN_SEL));

   cfm_activity_judge u_judge (
      .ref_clk (ref_clk),
      .rst_n   (rst_n),
      .enable  (enable),
      .sel_tog (sel_tog),
      .phase   (phase),
      .flag_clr(flag_clr),
      .fail_det(fail_det)
   );

   cfm_fail_response u_resp (
      .ref_clk       (ref_clk),
      .rst_n         (rst_n),
      .fail_det      (fail_det),
      .is_main       (is_main),
      .main_ext      (main_ext),
      .irq_en        (irq_en),
      .flag_clr      (flag_clr),
      .irq_flag      (irq_flag),
      .irq           (irq),
      .err_pulse     (err_pulse),
      .mc_reset_req  (mc_reset_req),
      .switch_int_osc(switch_int_osc),
      .cfg_to_default(cfg_to_default)
   );

   a_r1_judge_slot: assert property (@(posedge ref_clk) disable iff (!rst_n)
      err_pulse |-> $past(cnt) == CNT_W'(SAMPLE_LEN));
   a_r9_quiet_off: assert property (@(posedge ref_clk) disable iff (!rst_n)
      !enable |=> !err_pulse);
endmodule

// File: tb/clk_fail_mon_tb.sv
`timescale 1ns/1ps
module clk_fail_mon_tb;
   localparam int NS = 4;

   logic          ref_clk = 1'b0;
   logic          rst_n;
   logic [NS-1:0] mclk;
   logic [NS-1:0] run;
   logic          enable, main_ext, irq_en, flag_clr;
   logic [1:0]    src_sel;
   logic          irq_flag, irq, err_pulse, mc_reset_req, switch_int_osc, cfg_to_default;

   int n_chk  = 0;
   int n_fail = 0;

   always #2.5 ref_clk = ~ref_clk;

   for (genvar g = 0; g < NS; g++) begin : g_mclk
      logic mc = 1'b0;
      always begin
         #(6.5 + 2.0 * g);
         if (run[g]) mc = ~mc;
      end
      assign mclk[g] = mc;
   end

   clk_fail_mon u_dut (
      .ref_clk       (ref_clk),
      .rst_n         (rst_n),
      .mon_clk       (mclk),
      .enable        (enable),
      .src_sel       (src_sel),
      .main_ext      (main_ext),
      .irq_en        (irq_en),
      .flag_clr      (flag_clr),
      .irq_flag      (irq_flag),
      .irq           (irq),
      .err_pulse     (err_pulse),
      .mc_reset_req  (mc_reset_req),
      .switch_int_osc(switch_int_osc),
      .cfg_to_default(cfg_to_default)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: got %0d expected %0d (t=%0t)", req, what, act, exp, $time);
      end
   endtask

   task automatic tick();
      @(posedge ref_clk);
      @(negedge ref_clk);
   endtask

   task automatic check_outs(input string req, input bit e_err, input bit e_flag,
                             input bit e_mc, input bit e_sw, input bit ie);
      chk(req,  "err_pulse",      int'(err_pulse),      int'(e_err));
      chk("R4", "irq_flag",       int'(irq_flag),       int'(e_flag));
      chk("R5", "irq",            int'(irq),            int'(e_flag && ie));
      chk("R7", "mc_reset_req",   int'(mc_reset_req),   int'(e_mc));
      chk("R8", "switch_int_osc", int'(switch_int_osc), int'(e_sw));
      chk("R8", "cfg_to_default", int'(cfg_to_default), int'(e_sw));
   endtask

   // park the monitor with a cleared flag, selected clock in the wanted state
   task automatic prepare(input int s, input bit ext, input bit ie, input bit stop);
      enable   = 1'b0;
      src_sel  = 2'(s);
      main_ext = ext;
      irq_en   = ie;
      flag_clr = 1'b1;
      run      = stop ? ~(NS'(1) << s) : (NS'(1) << s);
      repeat (6) tick();
      flag_clr = 1'b0;
      tick();
      chk("R4", "flag after clear", int'(irq_flag), 0);
   endtask

   task automatic run_case(input int s, input bit ext, input bit ie, input bit stop);
      prepare(s, ext, ie, stop);
      enable = 1'b1;
      for (int k = 1; k <= 40; k++) begin
         bit    fire;
         bit    fl;
         string req;
         tick();
         fire = stop && (k == 9 || k == 29 || k == 39);
         fl   = stop && (k >= 9) && !(k >= 22 && k <= 28);
         if (!stop)        req = "R2";
         else if (k == 9)  req = "R1";
         else if (k == 10) req = "R6";
         else if (k == 19) req = "R10";
         else if (k == 29) req = "R10";
         else if (k == 39) req = "R11";
         else              req = "R3";
         check_outs(req, fire, fl, fire && s == 0 && !ext, fire && s == 0 && ext, ie);
         flag_clr = (k == 21 || k == 38);
      end
      flag_clr = 1'b0;
   endtask

   initial begin
      #500000;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      rst_n    = 1'b0;
      enable   = 1'b0;
      src_sel  = '0;
      main_ext = 1'b0;
      irq_en   = 1'b1;
      flag_clr = 1'b0;
      run      = '1;
      repeat (4) tick();
      check_outs("R6", 1'b0, 1'b0, 1'b0, 1'b0, 1'b1);
      rst_n = 1'b1;
      tick();

      // sweep: every source, both main-clock drivers, irq enable, running/stopped
      for (int s = 0; s < NS; s++)
         for (int e = 0; e < 2; e++)
            for (int ie = 0; ie < 2; ie++)
               for (int st = 0; st < 2; st++)
                  run_case(s, e[0], ie[0], st[0]);

      // R9: disable mid-window restarts the period
      prepare(1, 1'b0, 1'b1, 1'b1);
      enable = 1'b1;
      for (int k = 1; k <= 25; k++) begin
         tick();
         check_outs("R9", k == 16, k >= 16, 1'b0, 1'b0, 1'b1);
         if (k == 5) enable = 1'b0;
         if (k == 7) enable = 1'b1;
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule